// File: doc/BRIEF.md
# Task-Event UART Register Controller

This block is the register front end of a simple serial port. Software drives it with single-word writes to task addresses: start or stop the transmit side, start or stop the receive side, and pause both directions at once. The hardware reports what happened through sticky event words: a received byte is available, a transmitted byte was handed off, a line break was seen, and the receiver was halted. One interrupt line combines the four events, and each event has its own bit in an enable mask. The mask can be written whole, through a set alias or through a clear alias.

Bit-level shifting and baud generation are not part of this block. It exchanges whole bytes with the shifter. Transmit bytes leave through a valid/accept handshake. Received bytes come in through a push strobe into a small circular buffer whose depth is a parameter. A break strobe marks a line fault. The peripheral stays dormant until software writes the key value 4 to its enable word. Writing 0 to that word turns the peripheral off, halts both directions and raises the receiver-halted event. The bus is a 32-bit word-addressed port with a one-cycle read latency.

Word map: 0 start RX, 1 stop RX, 2 start TX, 3 stop TX, 4 pause, 5 RX-ready event, 6 TX-done event, 7 error event, 8 RX-halted event, 9 mask, 10 mask-set, 11 mask-clear, 12 error source, 13 enable, 14..17 pin selects, 18 RX data, 19 TX data, 20 baud word. Words from 21 up are plain storage.

Top module: `uart_evt_ctrl`

## Requirements
- R1: After reset the peripheral is disabled and both directions are stopped. The mask, events and error source read 0. The four pin-select words (14..17) read 0xFFFFFFFF. The baud word (20) reads 0x04000000. irq, tx_valid and rx_room are low.
- R2: Writing 4 to word 13 enables the peripheral. Any other nonzero value changes nothing. Writing 0 disables it, stops TX and RX, and sets the RX-halted event (word 8) to 1.
- R3: While the peripheral is disabled, every read returns 0 and every write except one to word 13 is ignored.
- R4: Writing word 9 replaces the mask, writing word 10 ORs the value into it, and writing word 11 clears the bits written as 1. A read of any of words 9, 10 or 11 returns the mask.
- R5: irq is high exactly when at least one event word is nonzero and its mask bit is set. The mask bits are: bit 0 RX-ready, bit 1 TX-done, bit 2 error, bit 3 RX-halted.
- R6: Task words act only when the written value is 1. Start RX/TX sets the running flag for that direction. Stop RX clears the RX flag and sets the RX-halted event. Pause clears both flags and sets the RX-halted event. Stop TX clears only the TX flag.
- R7: A write to word 19 is taken only while TX is running and no byte is pending. A taken byte appears on tx_data with tx_valid high, and both hold until tx_accept.
- R8: A cycle with tx_valid and tx_accept both high ends the pending byte and sets the TX-done event (word 6) to 1.
- R9: A push is stored only while RX is running and the buffer holds fewer than DEPTH bytes. rx_room shows exactly this condition. Each stored byte sets the RX-ready event (word 5) to 1.
- R10: Reading word 18 returns the oldest stored byte. The byte is removed only if RX is running and the buffer is non-empty. If bytes remain after a removal, the RX-ready event is set again. Storage wraps circularly at DEPTH entries.
- R11: break_in ORs 3 into the error source (word 12) and sets the error event (word 7) to 1. Writing word 12 clears the bits written as 1.
- R12: Writing 0 to the RX-ready event clears it, and a nonzero write leaves it unchanged. The other three event words take the written value. Writes to word 18 are ignored.
- R13: Pin-select, baud and all words from 21 up read back the last value written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_sel | input | 1 | Bus access this cycle |
| bus_we | input | 1 | 1 write, 0 read |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after the read |
| irq | output | 1 | Combined interrupt |
| tx_valid | output | 1 | A transmit byte is pending |
| tx_data | output | 8 | Pending transmit byte |
| tx_accept | input | 1 | Shifter takes the pending byte |
| rx_push | input | 1 | Shifter delivers a received byte |
| rx_byte | input | 8 | Received byte |
| rx_room | output | 1 | A push would be stored |
| break_in | input | 1 | Line break seen |

## Verification
The hardest state to reach is a receive buffer whose tail has wrapped past the last entry while older bytes are still waiting. To get there, the buffer is first filled to DEPTH, two bytes are drained, and two more are pushed. The wrapped pair must then come out after the four older bytes. The re-raising of the RX-ready event on a pop is isolated by clearing the event before each pop, including before the final pop that leaves the buffer empty. A pending transmit byte is held across an idle stretch and a rejected second write before the accept releases it.

// File: rtl/uart_evt_pkg.sv
package uart_evt_pkg;

  localparam int unsigned WORD_W = 32;
  localparam int unsigned BYTE_W = 8;

  // word map
  localparam logic [31:0] A_RXGO    = 32'd0;
  localparam logic [31:0] A_RXHALT  = 32'd1;
  localparam logic [31:0] A_TXGO    = 32'd2;
  localparam logic [31:0] A_TXHALT  = 32'd3;
  localparam logic [31:0] A_PAUSE   = 32'd4;
  localparam logic [31:0] A_EV_RXRDY = 32'd5;
  localparam logic [31:0] A_EV_TXDONE = 32'd6;
  localparam logic [31:0] A_EV_ERR  = 32'd7;
  localparam logic [31:0] A_EV_RXHLT = 32'd8;
  localparam logic [31:0] A_MASK    = 32'd9;
  localparam logic [31:0] A_MASKSET = 32'd10;
  localparam logic [31:0] A_MASKCLR = 32'd11;
  localparam logic [31:0] A_ERRSRC  = 32'd12;
  localparam logic [31:0] A_ENABLE  = 32'd13;
  localparam logic [31:0] A_PIN_LO  = 32'd14;
  localparam logic [31:0] A_PIN_HI  = 32'd17;
  localparam logic [31:0] A_RXDATA  = 32'd18;
  localparam logic [31:0] A_TXDATA  = 32'd19;
  localparam logic [31:0] A_BAUD    = 32'd20;

  // event index == mask bit
  localparam int unsigned EV_RXRDY  = 0;
  localparam int unsigned EV_TXDONE = 1;
  localparam int unsigned EV_ERR    = 2;
  localparam int unsigned EV_RXHLT  = 3;
  localparam int unsigned NUM_EV    = 4;

  localparam logic [31:0] ENABLE_KEY  = 32'd4;
  localparam logic [31:0] TASK_FIRE   = 32'd1;
  localparam logic [31:0] BAUD_RESET  = 32'h0400_0000;
  localparam logic [31:0] BREAK_BITS  = 32'd3;

  typedef logic [NUM_EV-1:0][WORD_W-1:0] ev_words_t;

  function automatic logic [WORD_W-1:0] plain_reset(input int unsigned idx);
    if (idx >= A_PIN_LO && idx <= A_PIN_HI) return '1;
    if (idx == A_BAUD) return BAUD_RESET;
    return '0;
  endfunction

  function automatic logic is_plain(input logic [31:0] idx);
    return (idx >= A_PIN_LO && idx <= A_PIN_HI) || (idx >= A_BAUD);
  endfunction

endpackage

// File: rtl/uart_evt_rxbuf.sv
module uart_evt_rxbuf #(
  parameter int unsigned DEPTH = 6,
  parameter int unsigned DW    = 8,
  localparam int unsigned PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned LW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  output logic [DW-1:0] head_data,
  output logic [LW-1:0] level,
  output logic          full,
  output logic          empty
);

  logic [DW-1:0] mem_q [DEPTH];
  logic [PW-1:0] head_q, head_nx, tail;
  logic [LW-1:0] cnt_q, cnt_nx;
  logic [31:0]   tsum;

  always_comb begin
    tsum = 32'(head_q) + 32'(cnt_q);
    if (tsum >= DEPTH) tsum = tsum - DEPTH;
    tail = PW'(tsum);
    head_nx = head_q;
    if (pop) head_nx = (head_q == PW'(DEPTH - 1)) ? '0 : head_q + 1'b1;
    cnt_nx = cnt_q;
    if (push && !pop) cnt_nx = cnt_q + 1'b1;
    else if (pop && !push) cnt_nx = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= '0;
      cnt_q  <= '0;
    end else if (push || pop) begin
      head_q <= head_nx;
      cnt_q  <= cnt_nx;
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic slot_we;
    assign slot_we = push && (tail == PW'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mem_q[i] <= '0;
      else if (slot_we) mem_q[i] <= push_data;
    end
  end

  assign head_data = mem_q[head_q];
  assign level     = cnt_q;
  assign full      = (cnt_q == LW'(DEPTH));
  assign empty     = (cnt_q == '0);

endmodule

// File: rtl/uart_evt_txhold.sv
module uart_evt_txhold #(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] load_data,
  input  logic          accept,
  output logic          valid,
  output logic [DW-1:0] data,
  output logic          handoff
);

  logic          valid_q, valid_nx;
  logic [DW-1:0] data_q, data_nx;

  always_comb begin
    valid_nx = valid_q;
    data_nx  = data_q;
    if (valid_q && accept) valid_nx = 1'b0;
    else if (!valid_q && load) begin
      valid_nx = 1'b1;
      data_nx  = load_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      data_q  <= '0;
    end else begin
      valid_q <= valid_nx;
      data_q  <= data_nx;
    end
  end

  assign valid   = valid_q;
  assign data    = data_q;
  assign handoff = valid_q && accept;

endmodule

// File: rtl/uart_evt_cfgstore.sv
module uart_evt_cfgstore
  import uart_evt_pkg::*;
#(
  parameter int unsigned ADDR_W = 5,
  localparam int unsigned NWORDS = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] rdata
);

  logic [WORD_W-1:0] word_q [NWORDS];

  for (genvar i = 0; i < NWORDS; i++) begin : g_word
    localparam logic [WORD_W-1:0] RST_VAL = plain_reset(i);
    logic word_we;
    assign word_we = we && (addr == ADDR_W'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) word_q[i] <= RST_VAL;
      else if (word_we) word_q[i] <= wdata;
    end
  end

  assign rdata = word_q[addr];

endmodule

// File: rtl/uart_evt_ctrl.sv
module uart_evt_ctrl
  import uart_evt_pkg::*;
#(
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned DEPTH  = 6,
  localparam int unsigned LW    = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq,
  output logic              tx_valid,
  output logic [7:0]        tx_data,
  input  logic              tx_accept,
  input  logic              rx_push,
  input  logic [7:0]        rx_byte,
  output logic              rx_room,
  input  logic              break_in
);

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_pipe;
  logic       rst_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_q = rst_pipe[1];

  // state
  logic        enabled, enabled_nx;
  logic        tx_run, tx_run_nx;
  logic        rx_run, rx_run_nx;
  ev_words_t   ev_q, ev_nx;
  logic [31:0] irq_mask, irq_mask_nx;
  logic [31:0] err_src, err_src_nx;
  logic [31:0] rdata_q, rdata_nx;

  // decode
  logic [31:0] word_idx;
  logic        wr, rd, pop, push_ok, tx_load, cfg_we, handoff;
  logic [7:0]  rx_head;
  logic [LW-1:0] rx_level;
  logic        rx_full, rx_empty;
  logic [31:0] cfg_rdata;

  assign word_idx = 32'(bus_addr);
  assign wr       = bus_sel && bus_we && (enabled || word_idx == A_ENABLE);
  assign rd       = bus_sel && !bus_we && enabled;
  assign pop      = rd && (word_idx == A_RXDATA) && rx_run && !rx_empty;
  assign push_ok  = rx_push && rx_run && !rx_full;
  assign tx_load  = wr && (word_idx == A_TXDATA) && tx_run;
  assign cfg_we   = wr && is_plain(word_idx);
  assign rx_room  = rx_run && !rx_full;

  uart_evt_rxbuf #(.DEPTH(DEPTH), .DW(BYTE_W)) u_rxbuf (
    .clk(clk), .rst_n(rst_q), .push(push_ok), .push_data(rx_byte), .pop(pop),
    .head_data(rx_head), .level(rx_level), .full(rx_full), .empty(rx_empty)
  );

  uart_evt_txhold #(.DW(BYTE_W)) u_txhold (
    .clk(clk), .rst_n(rst_q), .load(tx_load), .load_data(bus_wdata[7:0]),
    .accept(tx_accept), .valid(tx_valid), .data(tx_data), .handoff(handoff)
  );

  uart_evt_cfgstore #(.ADDR_W(ADDR_W)) u_cfg (
    .clk(clk), .rst_n(rst_q), .we(cfg_we), .addr(bus_addr),
    .wdata(bus_wdata), .rdata(cfg_rdata)
  );

  // next state: bus writes first, hardware events override
  always_comb begin
    enabled_nx  = enabled;
    tx_run_nx   = tx_run;
    rx_run_nx   = rx_run;
    ev_nx       = ev_q;
    irq_mask_nx = irq_mask;
    err_src_nx  = err_src;
    if (wr) begin
      case (word_idx)
        A_RXGO:   if (bus_wdata == TASK_FIRE) rx_run_nx = 1'b1;
        A_TXGO:   if (bus_wdata == TASK_FIRE) tx_run_nx = 1'b1;
        A_TXHALT: if (bus_wdata == TASK_FIRE) tx_run_nx = 1'b0;
        A_RXHALT: if (bus_wdata == TASK_FIRE) begin
          rx_run_nx = 1'b0;
          ev_nx[EV_RXHLT] = 32'd1;
        end
        A_PAUSE:  if (bus_wdata == TASK_FIRE) begin
          rx_run_nx = 1'b0;
          tx_run_nx = 1'b0;
          ev_nx[EV_RXHLT] = 32'd1;
        end
        A_EV_RXRDY:  if (bus_wdata == '0) ev_nx[EV_RXRDY] = '0;
        A_EV_TXDONE: ev_nx[EV_TXDONE] = bus_wdata;
        A_EV_ERR:    ev_nx[EV_ERR]    = bus_wdata;
        A_EV_RXHLT:  ev_nx[EV_RXHLT]  = bus_wdata;
        A_MASK:      irq_mask_nx = bus_wdata;
        A_MASKSET:   irq_mask_nx = irq_mask | bus_wdata;
        A_MASKCLR:   irq_mask_nx = irq_mask & ~bus_wdata;
        A_ERRSRC:    err_src_nx  = err_src & ~bus_wdata;
        A_ENABLE: begin
          if (bus_wdata == '0) begin
            enabled_nx = 1'b0;
            rx_run_nx  = 1'b0;
            tx_run_nx  = 1'b0;
            ev_nx[EV_RXHLT] = 32'd1;
          end else if (bus_wdata == ENABLE_KEY) begin
            enabled_nx = 1'b1;
          end
        end
        default: ;
      endcase
    end
    if (push_ok) ev_nx[EV_RXRDY] = 32'd1;
    if (pop && rx_level > LW'(1)) ev_nx[EV_RXRDY] = 32'd1;
    if (handoff) ev_nx[EV_TXDONE] = 32'd1;
    if (break_in) begin
      err_src_nx = err_src_nx | BREAK_BITS;
      ev_nx[EV_ERR] = 32'd1;
    end
  end

  // read path
  always_comb begin
    rdata_nx = '0;
    if (rd) begin
      case (word_idx)
        A_RXGO, A_RXHALT, A_TXGO, A_TXHALT, A_PAUSE: rdata_nx = '0;
        A_EV_RXRDY:  rdata_nx = ev_q[EV_RXRDY];
        A_EV_TXDONE: rdata_nx = ev_q[EV_TXDONE];
        A_EV_ERR:    rdata_nx = ev_q[EV_ERR];
        A_EV_RXHLT:  rdata_nx = ev_q[EV_RXHLT];
        A_MASK, A_MASKSET, A_MASKCLR: rdata_nx = irq_mask;
        A_ERRSRC:    rdata_nx = err_src;
        A_ENABLE:    rdata_nx = ENABLE_KEY;
        A_RXDATA:    rdata_nx = 32'(rx_head);
        A_TXDATA:    rdata_nx = 32'(tx_data);
        default:     rdata_nx = cfg_rdata;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      enabled  <= 1'b0;
      tx_run   <= 1'b0;
      rx_run   <= 1'b0;
      ev_q     <= '0;
      irq_mask <= '0;
      err_src  <= '0;
      rdata_q  <= '0;
    end else begin
      enabled  <= enabled_nx;
      tx_run   <= tx_run_nx;
      rx_run   <= rx_run_nx;
      ev_q     <= ev_nx;
      irq_mask <= irq_mask_nx;
      err_src  <= err_src_nx;
      rdata_q  <= rdata_nx;
    end
  end

  // interrupt combiner
  logic [NUM_EV-1:0] ev_hit;
  for (genvar e = 0; e < NUM_EV; e++) begin : g_irq
    assign ev_hit[e] = (ev_q[e] != '0) && irq_mask[e];
  end
  assign irq       = |ev_hit;
  assign bus_rdata = rdata_q;

endmodule

// File: rtl/uart_evt_chk.sv
module uart_evt_chk
  import uart_evt_pkg::*;
#(
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned DEPTH  = 6,
  localparam int unsigned LW    = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rst_q,
  input logic              bus_sel,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_wdata,
  input logic [31:0]       bus_rdata,
  input logic              enabled,
  input logic              tx_run,
  input logic              rx_run,
  input ev_words_t         ev_q,
  input logic [31:0]       irq_mask,
  input logic [31:0]       err_src,
  input logic              irq,
  input logic              tx_valid,
  input logic [7:0]        tx_data,
  input logic              tx_accept,
  input logic              break_in,
  input logic [LW-1:0]     rx_level
);

  AST_DISABLED_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_q)
    (bus_sel && !bus_we && !enabled) |=> (bus_rdata == '0)); // R3

  AST_DISABLE_STOPS: assert property (@(posedge clk) disable iff (!rst_q)
    (bus_sel && bus_we && 32'(bus_addr) == A_ENABLE && bus_wdata == '0)
    |=> (!enabled && !tx_run && !rx_run && ev_q[EV_RXHLT] != '0)); // R2

  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_q)
    (irq_mask[NUM_EV-1:0] == '0) |-> !irq); // R5

  AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_q)
    (tx_valid && !tx_accept) |=> (tx_valid && $stable(tx_data))); // R7

  AST_TX_HANDOFF: assert property (@(posedge clk) disable iff (!rst_q)
    (tx_valid && tx_accept) |=> (!tx_valid && ev_q[EV_TXDONE] != '0)); // R8

  AST_BREAK_FLAGS: assert property (@(posedge clk) disable iff (!rst_q)
    break_in |=> (err_src[1:0] == 2'b11 && ev_q[EV_ERR] != '0)); // R11

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_q)
    rx_level <= LW'(DEPTH)); // R9

endmodule

bind uart_evt_ctrl uart_evt_chk #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_q(rst_q), .bus_sel(bus_sel), .bus_we(bus_we),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .enabled(enabled), .tx_run(tx_run), .rx_run(rx_run), .ev_q(ev_q),
  .irq_mask(irq_mask), .err_src(err_src), .irq(irq), .tx_valid(tx_valid),
  .tx_data(tx_data), .tx_accept(tx_accept), .break_in(break_in),
  .rx_level(rx_level)
);

// File: tb/uart_evt_ctrl_tb.sv
module uart_evt_ctrl_tb;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 5;

  localparam logic [4:0] W_RXGO = 0, W_RXHALT = 1, W_TXGO = 2, W_TXHALT = 3,
    W_PAUSE = 4, W_EVRX = 5, W_EVTX = 6, W_EVERR = 7, W_EVHLT = 8,
    W_MASK = 9, W_MSET = 10, W_MCLR = 11, W_ERRSRC = 12, W_EN = 13,
    W_PIN0 = 14, W_PIN2 = 16, W_PIN3 = 17, W_RXD = 18, W_TXD = 19,
    W_BAUD = 20, W_SCR = 25;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_sel = 0, bus_we = 0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic irq, tx_valid, rx_room;
  logic [7:0] tx_data;
  logic tx_accept = 0, rx_push = 0, break_in = 0;
  logic [7:0] rx_byte = '0;

  int checks = 0, failures = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_evt_ctrl #(.ADDR_W(ADDR_W), .DEPTH(6)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq(irq), .tx_valid(tx_valid), .tx_data(tx_data), .tx_accept(tx_accept),
    .rx_push(rx_push), .rx_byte(rx_byte), .rx_room(rx_room), .break_in(break_in)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_we = 0;
  endtask

  task automatic rdchk(input string tag, input logic [4:0] a, input logic [31:0] exp);
    @(negedge clk);
    bus_sel = 1; bus_we = 0; bus_addr = a;
    @(negedge clk);
    bus_sel = 0;
    chk(tag, bus_rdata, exp);
  endtask

  task automatic push(input logic [7:0] b);
    @(negedge clk);
    rx_push = 1; rx_byte = b;
    @(negedge clk);
    rx_push = 0;
  endtask

  task automatic t_reset;
    rdchk("R3 read while disabled", W_BAUD, 32'h0);
    wr(W_EN, 32'd4);
    rdchk("R1 baud reset", W_BAUD, 32'h0400_0000);
    rdchk("R1 pin0 reset", W_PIN0, 32'hFFFF_FFFF);
    rdchk("R1 pin3 reset", W_PIN3, 32'hFFFF_FFFF);
    rdchk("R1 mask reset", W_MASK, 32'h0);
    rdchk("R1 event reset", W_EVRX, 32'h0);
    rdchk("R1 errsrc reset", W_ERRSRC, 32'h0);
    chk("R1 irq low", irq, 0);
    chk("R1 tx_valid low", tx_valid, 0);
    chk("R1 rx_room low", rx_room, 0);
  endtask

  task automatic t_enable;
    wr(W_EN, 32'd5);
    rdchk("R2 non-key keeps enabled", W_BAUD, 32'h0400_0000);
    wr(W_RXGO, 1); wr(W_TXGO, 1);
    chk("R6 rx start", rx_room, 1);
    wr(W_EN, 0);
    rdchk("R2 disabled by zero", W_BAUD, 32'h0);
    chk("R2 rx stopped by disable", rx_room, 0);
    wr(W_EN, 32'd4);
    rdchk("R2 rx-halted event", W_EVHLT, 32'd1);
    wr(W_TXD, 32'h11);
    chk("R2 tx stopped by disable", tx_valid, 0);
    wr(W_EVHLT, 0);
  endtask

  task automatic t_disabled;
    wr(W_EN, 0);
    wr(W_MASK, 32'hF);
    wr(W_SCR, 32'hCAFE);
    wr(W_EN, 32'd4);
    rdchk("R3 mask write ignored", W_MASK, 32'h0);
    rdchk("R3 scratch write ignored", W_SCR, 32'h0);
    wr(W_SCR, 32'hDEAD_BEEF);
    rdchk("R13 scratch readback", W_SCR, 32'hDEAD_BEEF);
    wr(W_PIN2, 32'h1F);
    rdchk("R13 pin readback", W_PIN2, 32'h1F);
    wr(W_EVHLT, 0);
  endtask

  task automatic t_mask;
    wr(W_MASK, 32'h5);
    rdchk("R4 mask replace", W_MASK, 32'h5);
    wr(W_MSET, 32'h2);
    rdchk("R4 mask set", W_MASK, 32'h7);
    wr(W_MCLR, 32'h4);
    rdchk("R4 read via set alias", W_MSET, 32'h3);
    rdchk("R4 read via clear alias", W_MCLR, 32'h3);
    wr(W_MASK, 0);
  endtask

  task automatic t_irq;
    wr(W_EVTX, 1);
    chk("R5 masked event no irq", irq, 0);
    wr(W_MSET, 32'h2);
    chk("R5 txdone bit1 irq", irq, 1);
    wr(W_EVTX, 0);
    chk("R5 event cleared irq low", irq, 0);
    wr(W_EVHLT, 32'd9);
    chk("R5 bit3 off no irq", irq, 0);
    wr(W_MSET, 32'h8);
    chk("R5 rx-halted bit3 irq", irq, 1);
    wr(W_MASK, 0);
    chk("R5 mask cleared irq low", irq, 0);
    wr(W_EVHLT, 0);
  endtask

  task automatic t_tx;
    wr(W_TXGO, 2);
    wr(W_TXD, 32'h5A);
    chk("R6 task value 2 no start", tx_valid, 0);
    wr(W_TXGO, 1);
    wr(W_TXD, 32'hA5);
    chk("R7 byte taken", tx_valid, 1);
    chk("R7 byte value", tx_data, 32'hA5);
    wr(W_TXD, 32'h3C);
    repeat (3) @(negedge clk);
    chk("R7 pending held", tx_valid, 1);
    chk("R7 second write rejected", tx_data, 32'hA5);
    @(negedge clk) tx_accept = 1;
    @(negedge clk) tx_accept = 0;
    chk("R8 pending cleared", tx_valid, 0);
    rdchk("R8 txdone event", W_EVTX, 32'd1);
    wr(W_RXGO, 1);
    wr(W_TXHALT, 1);
    chk("R6 stop-tx keeps rx", rx_room, 1);
    rdchk("R6 stop-tx no rx-halted", W_EVHLT, 32'd0);
    wr(W_TXD, 32'h77);
    chk("R6 stop-tx stops tx", tx_valid, 0);
    wr(W_PAUSE, 2);
    chk("R6 pause value 2 ignored", rx_room, 1);
    wr(W_TXGO, 1);
    wr(W_PAUSE, 1);
    chk("R6 pause stops rx", rx_room, 0);
    rdchk("R6 pause rx-halted", W_EVHLT, 32'd1);
    wr(W_TXD, 32'h42);
    chk("R6 pause stops tx", tx_valid, 0);
    wr(W_RXGO, 1);
    wr(W_EVHLT, 0);
    wr(W_RXHALT, 1);
    chk("R6 stop-rx", rx_room, 0);
    rdchk("R6 stop-rx rx-halted", W_EVHLT, 32'd1);
    wr(W_EVHLT, 0);
    wr(W_EVTX, 0);
  endtask

  task automatic t_rx;
    wr(W_RXGO, 1);
    for (int i = 0; i < 6; i++) push(8'h10 + 8'(i));
    chk("R9 full no room", rx_room, 0);
    rdchk("R9 push sets rx-ready", W_EVRX, 32'd1);
    push(8'h99);
    wr(W_EVRX, 32'd5);
    rdchk("R12 nonzero write no effect", W_EVRX, 32'd1);
    wr(W_EVRX, 0);
    rdchk("R12 zero clears rx-ready", W_EVRX, 32'd0);
    wr(W_RXD, 32'hEE);
    rdchk("R10 head byte", W_RXD, 32'h10);
    rdchk("R10 rx-ready reraised", W_EVRX, 32'd1);
    rdchk("R10 second byte", W_RXD, 32'h11);
    chk("R9 room after pops", rx_room, 1);
    push(8'h20); push(8'h21);
    chk("R9 full after wrap", rx_room, 0);
    for (int i = 2; i < 6; i++) rdchk("R10 order before wrap", W_RXD, 32'h10 + i);
    wr(W_EVRX, 0);
    rdchk("R10 wrapped byte", W_RXD, 32'h20);
    rdchk("R10 reraise after wrap", W_EVRX, 32'd1);
    wr(W_EVRX, 0);
    rdchk("R10 last byte", W_RXD, 32'h21);
    rdchk("R10 no reraise when empty", W_EVRX, 32'd0);
    chk("R9 room when empty", rx_room, 1);
    push(8'h33);
    wr(W_RXHALT, 1);
    rdchk("R10 stopped read", W_RXD, 32'h33);
    rdchk("R10 stopped read no pop", W_RXD, 32'h33);
    wr(W_EVERR, 32'd7);
    rdchk("R12 error event takes value", W_EVERR, 32'd7);
    wr(W_EVHLT, 0); wr(W_EVRX, 0);
  endtask

  task automatic t_break;
    wr(W_EVERR, 0);
    wr(W_MASK, 32'h4);
    chk("R11 no irq before break", irq, 0);
    @(negedge clk) break_in = 1;
    @(negedge clk) break_in = 0;
    chk("R11 break irq", irq, 1);
    rdchk("R11 error source", W_ERRSRC, 32'd3);
    rdchk("R11 error event", W_EVERR, 32'd1);
    wr(W_ERRSRC, 32'd1);
    rdchk("R11 write-one-clear", W_ERRSRC, 32'd2);
    wr(W_MASK, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    t_reset();
    t_enable();
    t_disabled();
    t_mask();
    t_irq();
    t_tx();
    t_rx();
    t_break();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule